// File: doc/BRIEF.md
# Repeated Phase Slip Controller

This block sits between the event sources of a clock distribution chip and a downstream output divider, and turns each incoming slip event into a burst of single-cycle phase slips. Four kinds of event can ask for a slip: a general-purpose input pin, a software register command, the end of a SYNC sequence and the start of the pulse generator. In single mode each accepted event produces one slip. In repeat mode each accepted event produces as many slips as the programmed count, so the divider phase moves by that many input clock cycles.

Every slip has a settling time, so slips are paced by the divider. The block raises a slip request and keeps it high until the divider acknowledges it, then either moves on to the next slip or finishes. An event that arrives during a burst is held in a one-deep queue and runs as a full burst afterwards. A further event while that queue is full is dropped and sets a sticky overflow flag. A done flag reports that no slip is in progress or queued. A zero count in repeat mode is a configuration error: the block flags it and issues no slips.

Top module: `phase_slip_burst`

## Requirements
- R1: With `cfg_multi_en`=0, an event on `ev_gpi` or `ev_reg` produces exactly one slip, whatever `cfg_count` holds.
- R2: With `cfg_multi_en`=1 and `cfg_count`=N (N>0), an event from any of the four sources produces exactly N slips. N is taken from `cfg_count` in the cycle the burst starts.
- R3: `ev_sync` and `ev_pgen` start a burst only when `cfg_multi_en`=1. When it is 0, they produce no slip.
- R4: `cfg_err` is 1 exactly when `cfg_multi_en`=1 and `cfg_count`=0. While it is 1, events produce no slips.
- R5: `slip_req` stays high until `slip_ack` is seen. Each cycle with both high is one slip. `slip_ack` while `slip_req` is low has no effect.
- R6: `done` rises in the cycle after the last acknowledged slip of a burst when nothing is queued. It is low while a burst runs or waits in the queue, and it is never high together with `slip_req`.
- R7: An event accepted during a burst is queued. The queued burst raises `slip_req` after one idle cycle that follows the last acknowledgement of the current burst.
- R8: An event accepted while one burst is already queued is dropped. It sets `ovf`, which stays high until reset.
- R9: A synchronous active-high `rst` leaves `slip_req`=0, `done`=1 and `ovf`=0, and empties the queue.
- R10: Events from several sources in the same cycle count as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_multi_en | input | 1 | 1 selects repeat mode |
| cfg_count | input | CNT_W (12) | Slips per event in repeat mode |
| ev_gpi | input | 1 | Slip event from the general-purpose pin (one cycle = one event) |
| ev_reg | input | 1 | Slip event from a register command |
| ev_sync | input | 1 | SYNC sequence completed |
| ev_pgen | input | 1 | Pulse generator started |
| slip_ack | input | 1 | Divider accepts the current slip |
| slip_req | output | 1 | Slip requested of the divider |
| done | output | 1 | No slip in progress or queued |
| cfg_err | output | 1 | Zero count in repeat mode |
| ovf | output | 1 | Sticky: a queued event was dropped |

## Verification
The bound checker checks these properties on every cycle:
- a request is held with an unchanged count until it is acknowledged;
- `done` and `slip_req` are never high together;
- `done` follows a final acknowledgement when nothing is queued;
- a single-mode burst has length one;
- a bad configuration never starts slips;
- overflow is sticky.

Only the bench scenarios can show the exact slip total for each source, mode and count under different acknowledgement spacings. The same holds for the one-cycle gap before a queued burst, the dropping of a third event, and the merging of events that arrive together.

// File: rtl/slip_burst_pkg.sv
package slip_burst_pkg;
  // number of slips one accepted event stands for
  function automatic int unsigned burst_len(input logic multi_en, input int unsigned count);
    return multi_en ? count : 1;
  endfunction

  // repeat mode with nothing to repeat is rejected
  function automatic logic cfg_bad(input logic multi_en, input int unsigned count);
    return multi_en && (count == 0);
  endfunction
endpackage

// File: rtl/slip_evt_merge.sv
module slip_evt_merge #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] AUTO_MASK = 4'b1100
) (
  input  logic [NSRC-1:0] ev,
  input  logic            multi_en,
  output logic            evt_any
);
  logic [NSRC-1:0] gated;
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (AUTO_MASK[i]) begin : g_auto
      assign gated[i] = ev[i] & multi_en;
    end else begin : g_plain
      assign gated[i] = ev[i];
    end
  end
  assign evt_any = |gated;
endmodule

// File: rtl/slip_burst_cnt.sv
module slip_burst_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             ack,
  output logic [CNT_W-1:0] rem,
  output logic             busy,
  output logic             hs,
  output logic             fin
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  assign busy = (rem != '0);
  assign hs   = busy && ack;
  assign fin  = hs && (rem == ONE);

  always_ff @(posedge clk) begin
    if (rst)       rem <= '0;
    else if (load) rem <= len;
    else if (hs)   rem <= rem - ONE;
  end
endmodule

// File: rtl/slip_req_queue.sv
module slip_req_queue (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic busy,
  output logic launch,
  output logic pend,
  output logic pend_nx,
  output logic ovf
);
  logic ovf_set;
  always_comb begin
    launch  = 1'b0;
    pend_nx = pend;
    ovf_set = 1'b0;
    if (!busy) begin
      if (pend) begin
        launch  = 1'b1;
        pend_nx = evt;
      end else if (evt) begin
        launch  = 1'b1;
      end
    end else if (evt) begin
      if (pend) ovf_set = 1'b1;
      else      pend_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      pend <= pend_nx;
      if (ovf_set) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_slip_burst.sv
module phase_slip_burst
  import slip_burst_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_multi_en,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             ev_gpi,
  input  logic             ev_reg,
  input  logic             ev_sync,
  input  logic             ev_pgen,
  input  logic             slip_ack,
  output logic             slip_req,
  output logic             done,
  output logic             cfg_err,
  output logic             ovf
);
  localparam int NSRC = 4;

  logic             evt_any, evt_ok, load, busy, hs, fin, pend, pend_nx, busy_nx;
  logic [CNT_W-1:0] len, rem;

  slip_evt_merge #(.NSRC(NSRC), .AUTO_MASK(4'b1100)) u_merge (
    .ev({ev_pgen, ev_sync, ev_reg, ev_gpi}),
    .multi_en(cfg_multi_en),
    .evt_any(evt_any)
  );

  assign cfg_err = cfg_bad(cfg_multi_en, int'(cfg_count));
  assign evt_ok  = evt_any && !cfg_err;
  assign len     = CNT_W'(burst_len(cfg_multi_en, int'(cfg_count)));

  slip_req_queue u_queue (
    .clk(clk), .rst(rst), .evt(evt_ok), .busy(busy),
    .launch(load), .pend(pend), .pend_nx(pend_nx), .ovf(ovf)
  );

  slip_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .len(len), .ack(slip_ack),
    .rem(rem), .busy(busy), .hs(hs), .fin(fin)
  );

  assign slip_req = busy;
  assign busy_nx  = load ? (len != '0) : (busy && !fin);

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b1;
    else     done <= !busy_nx && !pend_nx;
  end
endmodule

// File: rtl/slip_burst_chk.sv
module slip_burst_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_multi_en,
  input logic             slip_req,
  input logic             slip_ack,
  input logic             done,
  input logic             cfg_err,
  input logic             ovf,
  input logic             load,
  input logic             fin,
  input logic             pend,
  input logic             evt_ok,
  input logic [CNT_W-1:0] rem
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    slip_req && !slip_ack |=> slip_req && $stable(rem)); // R5
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    done |-> !slip_req); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    fin && !pend && !evt_ok |=> done); // R6
  AST_SINGLE_LEN: assert property (@(posedge clk) disable iff (rst)
    load && !cfg_multi_en |=> rem == CNT_W'(1)); // R1
  AST_ERR_NO_SLIP: assert property (@(posedge clk) disable iff (rst)
    cfg_err && !slip_req |=> !slip_req); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R8
endmodule

bind phase_slip_burst slip_burst_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_multi_en(cfg_multi_en), .slip_req(slip_req),
  .slip_ack(slip_ack), .done(done), .cfg_err(cfg_err), .ovf(ovf),
  .load(load), .fin(fin), .pend(pend), .evt_ok(evt_ok), .rem(rem)
);

// File: tb/tb_phase_slip_burst.sv
module tb_phase_slip_burst;
  localparam int CLK_P = 10;
  localparam int CNT_W = 12;

  logic clk = 1'b0, rst = 1'b1, multi = 1'b0, ack = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [3:0] ev = '0; // bit0 gpi, bit1 reg, bit2 sync, bit3 pgen
  logic slip_req, done, cfg_err, ovf;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  phase_slip_burst #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cfg_multi_en(multi), .cfg_count(cnt),
    .ev_gpi(ev[0]), .ev_reg(ev[1]), .ev_sync(ev[2]), .ev_pgen(ev[3]),
    .slip_ack(ack), .slip_req(slip_req), .done(done), .cfg_err(cfg_err), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_slips(input int src, input bit me, input int c);
    if (src >= 2 && !me) return 0;
    if (me && c == 0) return 0;
    return me ? c : 1;
  endfunction

  // acks slips with the given spacing; returns the number of slips taken
  task automatic drain(input int want, input int gap, output int got);
    got = 0;
    for (int k = 0; k < 20000 && got < want; k++) begin
      ack = slip_req && (k % (gap + 1) == gap);
      if (ack) got++;
      @(negedge clk);
    end
    ack = 1'b0;
  endtask

  task automatic burst(input int src, input bit me, input int c, input int gap);
    int e, got;
    e = exp_slips(src, me, c);
    multi = me; cnt = CNT_W'(c);
    @(negedge clk);
    chk(cfg_err == (me && c == 0), "R4 cfg_err", int'(cfg_err), int'(me && c == 0));
    ev[src] = 1'b1;
    @(negedge clk);
    ev = '0;
    if (e == 0) begin
      chk(!slip_req && done, "R3/R4 no slip", int'(slip_req), 0);
    end else begin
      chk(!done, "R6 done low in burst", int'(done), 0);
      drain(e, gap, got);
      chk(got == e, me ? "R2 slip count" : "R1 slip count", got, e);
      chk(done && !slip_req, "R6 done after last ack", int'(done), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!slip_req && done && !ovf, "R9 reset state", int'(done), 1);

    // R5: ack while idle must not cause anything
    ack = 1'b1; repeat (3) @(negedge clk); ack = 1'b0;
    chk(!slip_req && done, "R5 idle ack ignored", int'(slip_req), 0);

    // sweep over source, mode, count and ack spacing (R1 R2 R3 R4 R5 R6)
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 6; c++)
          for (int g = 0; g < 3; g++)
            burst(s, m[0], c, g);
    burst(1, 1'b1, 4095, 0); // R2 full count

    // R10: all sources at once count as one event
    multi = 1'b1; cnt = 3;
    ev = 4'hF; @(negedge clk); ev = '0;
    drain(10, 0, got);
    chk(got == 3, "R10 merged events", got, 3);
    chk(!ovf && done, "R10 no queue/overflow", int'(ovf), 0);

    // R7/R8: queue one, drop the next
    cnt = 4;
    ev[0] = 1'b1; @(negedge clk); ev = '0;
    ev[1] = 1'b1; @(negedge clk); ev = '0;
    chk(!ovf, "R7 first extra event queued", int'(ovf), 0);
    ev[0] = 1'b1; @(negedge clk); ev = '0;
    chk(ovf, "R8 overflow set", int'(ovf), 1);
    // finish first burst: 4 slips, one already possible at this point
    got = 0;
    while (got < 4) begin ack = slip_req; if (ack) got++; @(negedge clk); end
    ack = 1'b0;
    chk(!slip_req && !done, "R7 idle gap before queued burst", int'(slip_req), 0);
    @(negedge clk);
    chk(slip_req && !done, "R7 queued burst starts", int'(slip_req), 1);
    drain(4, 1, got);
    chk(got == 4, "R7 queued burst length", got, 4);
    chk(done && !slip_req, "R8 third event dropped", int'(slip_req), 0);
    repeat (3) @(negedge clk);
    chk(ovf, "R8 overflow sticky", int'(ovf), 1);

    // R4: error config keeps idle even with pending launch attempts
    cnt = 0;
    ev = 4'h3; @(negedge clk); ev = '0; @(negedge clk);
    chk(!slip_req && done, "R4 error blocks slips", int'(slip_req), 0);

    // R9: reset mid-burst
    cnt = 7;
    ev[0] = 1'b1; @(negedge clk); ev = '0;
    ev[1] = 1'b1; @(negedge clk); ev = '0;
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(!slip_req && done && !ovf, "R9 reset clears burst/queue/ovf", int'(slip_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule